// File: doc/BRIEF.md
# Omega Network Request and Reply Router

This block joins eight requesters to eight memory modules through three stages of 2x2 switching elements wired as an omega network. A requester offers a byte address and a write word. The block takes the module number from address bits [4:2], so consecutive 32-bit words go to consecutive modules. Each stage steers the packet with one bit of that number and then puts the number of the input port the packet came in on into the bit it used. A packet reaches its module carrying a path field that records its route. The memory side sends a reply back with that path field. The reverse datapath reads the field from the least significant bit upward and, at each stage, writes back the output port the reply came in on. The reply therefore reaches the original requester with the module number restored.

Requests and replies travel on separate datapaths. Every port uses a valid/ready handshake, and the switches hold no data, so a granted packet passes from edge to edge in the same cycle. The network is blocking: two packets that need the same switch output compete for it, even when their modules differ. Each switch output has a small arbitration state machine. Its four states are ARB_PREF_UP (upper input preferred, the state after reset), ARB_PREF_LO (lower input preferred), ARB_HOLD_UP and ARB_HOLD_LO (the output is locked to the upper or lower input while a packet waits for ready). The state machine makes these transitions. A completed transfer moves to the preference state of the input that did not win. An offered packet that is not accepted moves to the hold state of its input. A hold state whose input is no longer valid returns to the preference state for that same side. An idle preference state stays where it is.

Top module: `omega_router`

## Requirements
- R1: A request from any source reaches only the memory port whose index equals bits [4:2] of its byte address.
- R2: The path field delivered with a request holds, in its most significant bit, the input port used at the first stage, and in lower bits the ports used at the later stages (0 means upper, 1 means lower). Source 3 to module 6 gives 3'b011. Source 1 to module 1 gives 3'b001.
- R3: The address and write data reach the memory unchanged, and reply data reaches the requester unchanged.
- R4: Requests that share no switch output are all accepted, and all appear at the memory ports, in the same cycle they are offered. This holds for every cyclic shift of sources onto modules.
- R5: When two packets need one switch output, one is accepted and the other sees ready low and stays pending. This happens even if their modules differ (source 0 to module 0 against source 4 to module 1).
- R6: After reset every switch output prefers its upper input. After a transfer it prefers the input that did not win, so two packets that keep competing are served in turn.
- R7: While a switch output waits for ready, it keeps the same packet, even if the other input starts to compete.
- R8: A reply offered at module m with the path field of a request from source c is delivered to source c.
- R9: A delivered reply carries module number m in its module field.
- R10: Requests and replies cross the network in the same cycle without blocking each other.
- R11: After reset with no valid inputs, every valid output and every ready output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 8 | Request valid per source |
| req_ready | output | 8 | Request accepted per source |
| req_addr | input | 8x32 | Byte address per source |
| req_wdata | input | 8x32 | Write word per source |
| mem_req_valid | output | 8 | Request valid per memory module |
| mem_req_ready | input | 8 | Module can take a request |
| mem_req_path | output | 8x3 | Recorded path field per module |
| mem_req_addr | output | 8x32 | Delivered address per module |
| mem_req_wdata | output | 8x32 | Delivered write word per module |
| mem_rsp_valid | input | 8 | Reply valid per module |
| mem_rsp_ready | output | 8 | Reply accepted per module |
| mem_rsp_path | input | 8x3 | Path field returned with the reply |
| mem_rsp_rdata | input | 8x32 | Reply data per module |
| rsp_valid | output | 8 | Reply valid per source |
| rsp_ready | input | 8 | Source can take a reply |
| rsp_module | output | 8x3 | Restored module number per source |
| rsp_rdata | output | 8x32 | Reply data per source |

## Verification
No stage holds data, so routing, path recording, handshake readies and reply delivery all show in the same cycle the inputs are driven. The bench drives just after a rising edge and samples at the falling edge of that cycle. Arbitration results depend on state that changes only at a transfer edge. The conflict, hold and turn-taking checks therefore start from a fresh reset, and each is read one cycle after the transfer that moved the preference. A waiting packet is checked both in the cycle a competitor arrives and in the cycle ready is finally raised.

// File: rtl/omega_pkg.sv
package omega_pkg;

    typedef enum logic [1:0] {
        ARB_PREF_UP,
        ARB_PREF_LO,
        ARB_HOLD_UP,
        ARB_HOLD_LO
    } arb_state_e;

    // rotate a line index left by one within a field of the given width
    function automatic int rotl_idx(int idx, int bits);
        return ((idx << 1) | (idx >> (bits - 1))) & ((1 << bits) - 1);
    endfunction

    // rotate a line index right by one within a field of the given width
    function automatic int rotr_idx(int idx, int bits);
        return ((idx >> 1) | ((idx & 1) << (bits - 1))) & ((1 << bits) - 1);
    endfunction

endpackage

// File: rtl/omega_arb.sv
module omega_arb
    import omega_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_up,
    input  logic req_lo,
    input  logic out_ready,
    output logic out_valid,
    output logic sel_lo,
    output logic gnt_up,
    output logic gnt_lo
);

    arb_state_e state_q;
    arb_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_PREF_UP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        out_valid = 1'b0;
        sel_lo    = 1'b0;
        unique case (state_q)
            ARB_PREF_UP: begin
                out_valid = req_up | req_lo;
                sel_lo    = ~req_up;
            end
            ARB_PREF_LO: begin
                out_valid = req_up | req_lo;
                sel_lo    = req_lo;
            end
            ARB_HOLD_UP: begin
                out_valid = req_up;
                sel_lo    = 1'b0;
            end
            ARB_HOLD_LO: begin
                out_valid = req_lo;
                sel_lo    = 1'b1;
            end
        endcase

        gnt_up = out_valid & ~sel_lo & out_ready;
        gnt_lo = out_valid & sel_lo & out_ready;

        state_d = state_q;
        if (out_valid && out_ready) begin
            state_d = sel_lo ? ARB_PREF_UP : ARB_PREF_LO;
        end else if (out_valid) begin
            state_d = sel_lo ? ARB_HOLD_LO : ARB_HOLD_UP;
        end else if (state_q == ARB_HOLD_UP) begin
            state_d = ARB_PREF_UP;
        end else if (state_q == ARB_HOLD_LO) begin
            state_d = ARB_PREF_LO;
        end
    end

    // a waiting output keeps offering the same input's packet
    p_hold_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && sel_lo == $past(sel_lo)));

    // after the upper input wins with the lower one pending, the lower one is next
    p_turn_to_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !sel_lo && req_lo) |=> (!out_valid || sel_lo));

    // after the lower input wins with the upper one pending, the upper one is next
    p_turn_to_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && sel_lo && req_up) |=> (!out_valid || !sel_lo));

endmodule

// File: rtl/omega_switch.sv
module omega_switch #(
    parameter int N  = 3,
    parameter int BP = 2,
    parameter int PW = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           in_valid,
    output logic [1:0]           in_ready,
    input  logic [1:0][N-1:0]    in_tag,
    input  logic [1:0][PW-1:0]   in_pay,
    output logic [1:0]           out_valid,
    input  logic [1:0]           out_ready,
    output logic [1:0][N-1:0]    out_tag,
    output logic [1:0][PW-1:0]   out_pay
);

    logic [1:0] sel;
    logic [1:0] gnt [2];

    for (genvar o = 0; o < 2; o++) begin : g_out
        logic [N-1:0] tag_pick;

        omega_arb u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_up    (in_valid[0] && (in_tag[0][BP] == 1'(o))),
            .req_lo    (in_valid[1] && (in_tag[1][BP] == 1'(o))),
            .out_ready (out_ready[o]),
            .out_valid (out_valid[o]),
            .sel_lo    (sel[o]),
            .gnt_up    (gnt[o][0]),
            .gnt_lo    (gnt[o][1])
        );

        // the consumed steering bit now records the arrival port
        always_comb begin
            tag_pick     = sel[o] ? in_tag[1] : in_tag[0];
            tag_pick[BP] = sel[o];
        end

        assign out_tag[o] = tag_pick;
        assign out_pay[o] = sel[o] ? in_pay[1] : in_pay[0];
    end

    for (genvar i = 0; i < 2; i++) begin : g_in
        assign in_ready[i] = gnt[0][i] | gnt[1][i];

        p_path_record_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[i] && in_ready[i]) |->
                (out_valid[in_tag[i][BP]] && out_tag[in_tag[i][BP]][BP] == 1'(i)));

        p_payload_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[i] && in_ready[i]) |-> (out_pay[in_tag[i][BP]] == in_pay[i]));
    end

endmodule

// File: rtl/omega_router.sv
module omega_router
    import omega_pkg::*;
#(
    parameter int N  = 3,
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int RW = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [(1<<N)-1:0]           req_valid,
    output logic [(1<<N)-1:0]           req_ready,
    input  logic [(1<<N)-1:0][AW-1:0]   req_addr,
    input  logic [(1<<N)-1:0][DW-1:0]   req_wdata,
    output logic [(1<<N)-1:0]           mem_req_valid,
    input  logic [(1<<N)-1:0]           mem_req_ready,
    output logic [(1<<N)-1:0][N-1:0]    mem_req_path,
    output logic [(1<<N)-1:0][AW-1:0]   mem_req_addr,
    output logic [(1<<N)-1:0][DW-1:0]   mem_req_wdata,
    input  logic [(1<<N)-1:0]           mem_rsp_valid,
    output logic [(1<<N)-1:0]           mem_rsp_ready,
    input  logic [(1<<N)-1:0][N-1:0]    mem_rsp_path,
    input  logic [(1<<N)-1:0][RW-1:0]   mem_rsp_rdata,
    output logic [(1<<N)-1:0]           rsp_valid,
    input  logic [(1<<N)-1:0]           rsp_ready,
    output logic [(1<<N)-1:0][N-1:0]    rsp_module,
    output logic [(1<<N)-1:0][RW-1:0]   rsp_rdata
);

    localparam int NP = 1 << N;
    localparam int NS = NP / 2;
    localparam int FW = AW + DW;
    localparam int MB = 2;   // word-interleave offset of the module field

    // forward (request) datapath: stage inputs and stage outputs
    logic [NP-1:0]         fi_v [N];
    logic [NP-1:0]         fi_r [N];
    logic [NP-1:0][N-1:0]  fi_t [N];
    logic [NP-1:0][FW-1:0] fi_p [N];
    logic [NP-1:0]         fo_v [N];
    logic [NP-1:0]         fo_r [N];
    logic [NP-1:0][N-1:0]  fo_t [N];
    logic [NP-1:0][FW-1:0] fo_p [N];

    // reverse (reply) datapath: memory-side and source-side of each stage
    logic [NP-1:0]         rd_v [N];
    logic [NP-1:0]         rd_r [N];
    logic [NP-1:0][N-1:0]  rd_t [N];
    logic [NP-1:0][RW-1:0] rd_p [N];
    logic [NP-1:0]         ru_v [N];
    logic [NP-1:0]         ru_r [N];
    logic [NP-1:0][N-1:0]  ru_t [N];
    logic [NP-1:0][RW-1:0] ru_p [N];

    for (genvar s = 0; s < N; s++) begin : g_stage
        for (genvar k = 0; k < NS; k++) begin : g_sw
            omega_switch #(.N(N), .BP(N - 1 - s), .PW(FW)) u_fwd (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (fi_v[s][2*k+1:2*k]),
                .in_ready  (fi_r[s][2*k+1:2*k]),
                .in_tag    (fi_t[s][2*k+1:2*k]),
                .in_pay    (fi_p[s][2*k+1:2*k]),
                .out_valid (fo_v[s][2*k+1:2*k]),
                .out_ready (fo_r[s][2*k+1:2*k]),
                .out_tag   (fo_t[s][2*k+1:2*k]),
                .out_pay   (fo_p[s][2*k+1:2*k])
            );

            omega_switch #(.N(N), .BP(N - 1 - s), .PW(RW)) u_rev (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (rd_v[s][2*k+1:2*k]),
                .in_ready  (rd_r[s][2*k+1:2*k]),
                .in_tag    (rd_t[s][2*k+1:2*k]),
                .in_pay    (rd_p[s][2*k+1:2*k]),
                .out_valid (ru_v[s][2*k+1:2*k]),
                .out_ready (ru_r[s][2*k+1:2*k]),
                .out_tag   (ru_t[s][2*k+1:2*k]),
                .out_pay   (ru_p[s][2*k+1:2*k])
            );
        end

        for (genvar j = 0; j < NP; j++) begin : g_line
            localparam int PREV = rotr_idx(j, N);   // shuffle feeding input line j
            localparam int NEXT = rotl_idx(j, N);   // line j of the next stage's input side

            if (s == 0) begin : g_src
                assign fi_v[0][j]    = req_valid[PREV];
                assign fi_t[0][j]    = req_addr[PREV][MB+N-1:MB];
                assign fi_p[0][j]    = {req_addr[PREV], req_wdata[PREV]};
                assign req_ready[PREV] = fi_r[0][j];

                assign rsp_valid[PREV]  = ru_v[0][j];
                assign rsp_module[PREV] = ru_t[0][j];
                assign rsp_rdata[PREV]  = ru_p[0][j];
                assign ru_r[0][j]       = rsp_ready[PREV];
            end else begin : g_mid
                assign fi_v[s][j]      = fo_v[s-1][PREV];
                assign fi_t[s][j]      = fo_t[s-1][PREV];
                assign fi_p[s][j]      = fo_p[s-1][PREV];
                assign fo_r[s-1][PREV] = fi_r[s][j];
            end

            if (s == N - 1) begin : g_mem
                assign mem_req_valid[j] = fo_v[s][j];
                assign mem_req_path[j]  = fo_t[s][j];
                assign mem_req_addr[j]  = fo_p[s][j][FW-1:DW];
                assign mem_req_wdata[j] = fo_p[s][j][DW-1:0];
                assign fo_r[s][j]       = mem_req_ready[j];

                assign rd_v[s][j]       = mem_rsp_valid[j];
                assign rd_t[s][j]       = mem_rsp_path[j];
                assign rd_p[s][j]       = mem_rsp_rdata[j];
                assign mem_rsp_ready[j] = rd_r[s][j];
            end else begin : g_rev
                assign rd_v[s][j]       = ru_v[s+1][NEXT];
                assign rd_t[s][j]       = ru_t[s+1][NEXT];
                assign rd_p[s][j]       = ru_p[s+1][NEXT];
                assign ru_r[s+1][NEXT]  = rd_r[s][j];
            end
        end
    end

    // a source is never told its request was taken unless it offered one
    p_ready_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_ready & ~req_valid) == '0));

    // a reply is never presented to a source that had no module send one
    p_reply_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid == '0) |-> (rsp_valid == '0));

endmodule

// File: tb/test_omega_router.sv
module test_omega_router;

    localparam int N  = 3;
    localparam int NP = 8;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NP-1:0]          req_valid = '0;
    logic [NP-1:0]          req_ready;
    logic [NP-1:0][31:0]    req_addr = '0;
    logic [NP-1:0][31:0]    req_wdata = '0;
    logic [NP-1:0]          mem_req_valid;
    logic [NP-1:0]          mem_req_ready = '1;
    logic [NP-1:0][N-1:0]   mem_req_path;
    logic [NP-1:0][31:0]    mem_req_addr;
    logic [NP-1:0][31:0]    mem_req_wdata;
    logic [NP-1:0]          mem_rsp_valid = '0;
    logic [NP-1:0]          mem_rsp_ready;
    logic [NP-1:0][N-1:0]   mem_rsp_path = '0;
    logic [NP-1:0][31:0]    mem_rsp_rdata = '0;
    logic [NP-1:0]          rsp_valid;
    logic [NP-1:0]          rsp_ready = '1;
    logic [NP-1:0][N-1:0]   rsp_module;
    logic [NP-1:0][31:0]    rsp_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    omega_router i_omega_router (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_path  (mem_req_path),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_ready (mem_rsp_ready),
        .mem_rsp_path  (mem_rsp_path),
        .mem_rsp_rdata (mem_rsp_rdata),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_module    (rsp_module),
        .rsp_rdata     (rsp_rdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // path field from the requirement: ports taken per stage, MSB first
    function automatic logic [2:0] exp_path(int src, int mod);
        int line;
        logic [2:0] t;
        line = ((src << 1) | (src >> 2)) & 7;
        for (int s = 0; s < 3; s++) begin
            t[2-s] = line[0];
            line = (line & 6) | ((mod >> (2 - s)) & 1);
            if (s < 2) line = ((line << 1) | (line >> 2)) & 7;
        end
        return t;
    endfunction

    function automatic logic [31:0] mk_addr(int src, int mod);
        return 32'h4000_0000 | (32'(src) << 8) | (32'(mod) << 2);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic sample();
        @(negedge clk);
    endtask

    task automatic clear();
        req_valid = '0;
        mem_rsp_valid = '0;
        mem_req_ready = '1;
        rsp_ready = '1;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        clear();
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        sample();
        check("R11 mem_req_valid", 64'(mem_req_valid), 64'h0);
        check("R11 rsp_valid", 64'(rsp_valid), 64'h0);
        check("R11 req_ready", 64'(req_ready), 64'h0);
        check("R11 mem_rsp_ready", 64'(mem_rsp_ready), 64'h0);
    endtask

    task automatic t_route();
        do_reset();
        for (int c = 0; c < NP; c++) begin
            int m;
            m = (c * 3 + 5) % NP;
            req_valid = '0;
            req_valid[c] = 1'b1;
            req_addr[c] = mk_addr(c, m);
            req_wdata[c] = 32'hA500_0000 | 32'(c);
            sample();
            check("R1 module select", 64'(mem_req_valid), 64'(8'(1) << m));
            check("R2 path field", 64'(mem_req_path[m]), 64'(exp_path(c, m)));
            check("R3 address kept", 64'(mem_req_addr[m]), 64'(mk_addr(c, m)));
            check("R3 data kept", 64'(mem_req_wdata[m]), 64'(32'hA500_0000 | 32'(c)));
            step();
        end
        req_valid = '0;
        req_valid[3] = 1'b1;
        req_addr[3] = mk_addr(3, 6);
        sample();
        check("R2 source 3 to module 6", 64'(mem_req_path[6]), 64'h3);
        step();
        req_valid = '0;
        req_valid[1] = 1'b1;
        req_addr[1] = mk_addr(1, 1);
        sample();
        check("R2 source 1 to module 1", 64'(mem_req_path[1]), 64'h1);
        step();
        clear();
    endtask

    task automatic t_parallel();
        do_reset();
        for (int k = 0; k < NP; k++) begin
            int ok;
            for (int c = 0; c < NP; c++) begin
                req_addr[c] = mk_addr(c, (c + k) % NP);
                req_wdata[c] = 32'(k * 16 + c);
            end
            req_valid = '1;
            sample();
            check("R4 all accepted", 64'(req_ready), 64'hFF);
            check("R4 all delivered", 64'(mem_req_valid), 64'hFF);
            ok = 1;
            for (int c = 0; c < NP; c++)
                if (mem_req_addr[(c + k) % NP] !== mk_addr(c, (c + k) % NP)) ok = 0;
            check("R4 shift mapping", 64'(ok), 64'h1);
            step();
        end
        clear();
    endtask

    task automatic t_conflict();
        do_reset();
        req_valid = '0;
        req_valid[0] = 1'b1;
        req_addr[0] = mk_addr(0, 0);
        req_valid[4] = 1'b1;
        req_addr[4] = mk_addr(4, 1);
        sample();
        check("R5 one accepted, upper first", 64'(req_ready), 64'h01);
        check("R5 only module 0", 64'(mem_req_valid), 64'h01);
        step();
        req_valid[0] = 1'b0;
        sample();
        check("R5 blocked one served next", 64'(req_ready), 64'h10);
        check("R5 reaches module 1", 64'(mem_req_valid), 64'h02);
        step();
        clear();

        // both keep competing for module 0: they must alternate
        do_reset();
        req_valid = '0;
        req_valid[0] = 1'b1;
        req_addr[0] = mk_addr(0, 0);
        req_valid[4] = 1'b1;
        req_addr[4] = mk_addr(4, 0);
        for (int n = 0; n < 4; n++) begin
            int w;
            w = (n % 2 == 0) ? 0 : 4;
            sample();
            check("R6 turn taking", 64'(mem_req_addr[0]), 64'(mk_addr(w, 0)));
            check("R6 turn ready", 64'(req_ready), 64'(8'(1) << w));
            step();
        end
        clear();
    endtask

    task automatic t_hold();
        do_reset();
        mem_req_ready = '1;
        mem_req_ready[0] = 1'b0;
        req_valid = '0;
        req_valid[4] = 1'b1;
        req_addr[4] = mk_addr(4, 0);
        sample();
        check("R7 waiting packet shown", 64'(mem_req_addr[0]), 64'(mk_addr(4, 0)));
        check("R7 not accepted", 64'(req_ready), 64'h00);
        step();
        req_valid[0] = 1'b1;
        req_addr[0] = mk_addr(0, 0);
        sample();
        check("R7 competitor does not steal", 64'(mem_req_addr[0]), 64'(mk_addr(4, 0)));
        check("R7 nothing accepted", 64'(req_ready), 64'h00);
        step();
        mem_req_ready[0] = 1'b1;
        sample();
        check("R7 held packet accepted", 64'(req_ready), 64'h10);
        step();
        req_valid[4] = 1'b0;
        sample();
        check("R7 competitor next", 64'(mem_req_addr[0]), 64'(mk_addr(0, 0)));
        step();
        clear();
    endtask

    task automatic t_reply();
        do_reset();
        for (int c = 0; c < NP; c++) begin
            int m;
            m = (c * 5 + 2) % NP;
            mem_rsp_valid = '0;
            mem_rsp_valid[m] = 1'b1;
            mem_rsp_path[m] = exp_path(c, m);
            mem_rsp_rdata[m] = 32'hC0DE_0000 | 32'(c);
            sample();
            check("R8 reply to source", 64'(rsp_valid), 64'(8'(1) << c));
            check("R9 module restored", 64'(rsp_module[c]), 64'(m));
            check("R3 reply data kept", 64'(rsp_rdata[c]), 64'(32'hC0DE_0000 | 32'(c)));
            check("R8 reply accepted", 64'(mem_rsp_ready), 64'(8'(1) << m));
            step();
        end
        mem_rsp_valid = '0;
        mem_rsp_valid[6] = 1'b1;
        mem_rsp_path[6] = 3'b011;
        sample();
        check("R8 path 011 from module 6", 64'(rsp_valid), 64'h08);
        step();
        clear();
    endtask

    task automatic t_reply_conflict();
        do_reset();
        mem_rsp_valid = '0;
        mem_rsp_valid[0] = 1'b1;
        mem_rsp_path[0] = exp_path(0, 0);
        mem_rsp_rdata[0] = 32'h1111_0000;
        mem_rsp_valid[1] = 1'b1;
        mem_rsp_path[1] = exp_path(0, 1);
        mem_rsp_rdata[1] = 32'h2222_0000;
        sample();
        check("R5 reverse one accepted", 64'(mem_rsp_ready), 64'h01);
        check("R9 reverse module 0 first", 64'(rsp_module[0]), 64'h0);
        step();
        mem_rsp_valid[0] = 1'b0;
        sample();
        check("R6 reverse second served", 64'(mem_rsp_ready), 64'h02);
        check("R9 reverse module 1 next", 64'(rsp_module[0]), 64'h1);
        step();
        clear();
    endtask

    task automatic t_mixed();
        do_reset();
        for (int c = 0; c < NP; c++) begin
            req_addr[c] = mk_addr(c, c);
            mem_rsp_path[c] = exp_path(c, c);
            mem_rsp_rdata[c] = 32'(c);
        end
        req_valid = '1;
        mem_rsp_valid = '1;
        sample();
        check("R10 requests pass", 64'(req_ready), 64'hFF);
        check("R10 replies pass", 64'(mem_rsp_ready), 64'hFF);
        check("R10 replies delivered", 64'(rsp_valid), 64'hFF);
        step();
        clear();
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_route();
                t_parallel();
                t_conflict();
                t_hold();
                t_reply();
                t_reply_conflict();
                t_mixed();
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    total++;
                    bad++;
                    $display("FAIL watchdog actual=running expected=finished");
                end
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule